// File: doc/BRIEF.md
# Bidirectional Parity Bus Transceiver

This block joins two 8-bit bus segments, called the A side and the B side, and moves data across in one direction at a time. A direction input chooses the sender: high carries A onto B, low carries B onto A. An active-high release input takes every driver off the wires at once. A single parity pin travels with the data. When A sends, the block drives the pin with a parity bit that it generates. When B sends, the block reads the pin and checks it against the received byte. The result goes to an active-low error flag.

Each bidirectional wire is split into an input, an output value and a drive-enable, so the block stays synthesizable inside a larger chip. The pad ring or a top-level mux combines them. A select input chooses even or odd parity. With the default parameters every output value and every drive-enable is registered once, so the error flag comes out together with the received byte after the same edge.

Top module: `ptx_parity_xcvr`

## Requirements
- R1: While enabled (`hiz_all`=0) with `dir_a2b`=1, `b_oe` is 1, `a_oe` is 0 and `b_out` equals `a_in`.
- R2: While enabled with `dir_a2b`=0, `a_oe` is 1, `b_oe` is 0 and `a_out` equals `b_in`.
- R3: With `hiz_all`=1, `a_oe`, `b_oe`, `par_oe` and `err_oe` are all 0 and `err_n` is 1, whatever the other inputs are.
- R4: While enabled with `dir_a2b`=1 and `odd_sel`=0 (even), `par_oe` is 1. `par_out` is 1 exactly when `a_in` holds an odd number of ones, so the byte plus the bit has an even count of ones.
- R5: `odd_sel`=1 (odd) inverts the generated parity bit and also inverts the parity that the checker expects.
- R6: While enabled with `dir_a2b`=0, `par_oe` is 0 and `err_oe` is 1. `err_n` is 1 (no error) when the ones in `b_in` plus `par_in` form an even count under even select or an odd count under odd select. Otherwise `err_n` is 0.
- R7: While enabled with `dir_a2b`=1, `err_oe` is 1 and `err_n` is held at 1. No check is made in this direction.
- R8: With `REG_OUT`=1, every output value and drive-enable reflects the inputs present at the previous rising `clk` edge. While `rst_n`=0, all drive-enables are 0, `err_n` is 1, and `a_out`, `b_out` and `par_out` are 0.
- R9: `a_oe` and `b_oe` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a2b | input | 1 | 1: A side sends to B; 0: B side sends to A |
| hiz_all | input | 1 | 1: release all drivers |
| odd_sel | input | 1 | 0: even parity, 1: odd parity |
| a_in | input | DATA_W | Value seen on the A wires |
| a_out | output | DATA_W | Value to drive on the A wires |
| a_oe | output | 1 | Drive-enable for the A wires |
| b_in | input | DATA_W | Value seen on the B wires |
| b_out | output | DATA_W | Value to drive on the B wires |
| b_oe | output | 1 | Drive-enable for the B wires |
| par_in | input | 1 | Value seen on the parity wire |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive-enable for the parity wire |
| err_n | output | 1 | Active-low parity error flag |
| err_oe | output | 1 | Drive-enable for the error flag |

## Verification
Parity generation and parity checking can switch places from one cycle to the next. The same wire changes from driven to sensed while the error flag changes from held high to live. A second overlap is a release request that arrives in the same cycle as a parity mismatch. The stimulus walks every data byte through every setting of direction, parity select, incoming parity level and release. Direction toggles on every cycle, so each hand-over of the parity pin is exercised in both senses. A scoreboard predicts every enable, data value, parity bit and error level one edge later. In the release cycles it expects every enable to be low and the flag to be high, even when the sensed parity is wrong.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

   typedef enum logic {
      XFER_B2A = 1'b0,
      XFER_A2B = 1'b1
   } xfer_dir_e;

   typedef struct packed {
      logic a_en;
      logic b_en;
      logic par_en;
      logic err_en;
   } drive_en_t;

endpackage

// File: rtl/ptx_parity_tree.sv
module ptx_parity_tree #(
   parameter int DATA_W   = 8,
   parameter bit BALANCED = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   output logic              odd
);
   localparam int LEVELS = (DATA_W > 1) ? $clog2(DATA_W) : 0;
   localparam int LEAVES = 1 << LEVELS;

   if (DATA_W < 1) begin : g_bad_width
      $error("ptx_parity_tree: DATA_W must be at least 1");
   end

   if (BALANCED) begin : g_tree
      logic [2*LEAVES-1:0] node;
      assign node[0] = 1'b0;
      for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
         if (i < DATA_W) begin : g_real
            assign node[LEAVES+i] = data[i];
         end else begin : g_pad
            assign node[LEAVES+i] = 1'b0;
         end
      end
      for (genvar k = 1; k < LEAVES; k++) begin : g_inner
         assign node[k] = node[2*k] ^ node[2*k+1];
      end
      assign odd = node[1];
   end else begin : g_chain
      always_comb begin
         odd = 1'b0;
         for (int i = 0; i < DATA_W; i++) begin
            odd = odd ^ data[i];
         end
      end
   end
endmodule

// File: rtl/ptx_dir_ctrl.sv
module ptx_dir_ctrl
   import ptx_pkg::*;
(
   input  logic      dir_a2b,
   input  logic      hiz_all,
   output drive_en_t en
);
   xfer_dir_e dir;
   assign dir = xfer_dir_e'(dir_a2b);

   always_comb begin
      en        = '0;
      if (!hiz_all) begin
         en.err_en = 1'b1;
         unique case (dir)
            XFER_A2B: begin
               en.b_en   = 1'b1;
               en.par_en = 1'b1;
            end
            XFER_B2A: begin
               en.a_en   = 1'b1;
            end
            default: en = '0;
         endcase
      end
   end
endmodule

// File: rtl/ptx_rx_check.sv
module ptx_rx_check (
   input  logic rx_live,
   input  logic odd_sel,
   input  logic b_odd,
   input  logic par_in,
   output logic err_n
);
   logic want_par;
   assign want_par = b_odd ^ odd_sel;
   assign err_n    = rx_live ? (par_in == want_par) : 1'b1;
endmodule

// File: rtl/ptx_parity_xcvr.sv
module ptx_parity_xcvr
   import ptx_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit REG_OUT       = 1'b1,
   parameter bit BALANCED_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_a2b,
   input  logic              hiz_all,
   input  logic              odd_sel,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe,
   input  logic              par_in,
   output logic              par_out,
   output logic              par_oe,
   output logic              err_n,
   output logic              err_oe
);
   if (DATA_W < 1) begin : g_bad_width
      $error("ptx_parity_xcvr: DATA_W must be at least 1");
   end

   drive_en_t en;
   logic      a_odd;
   logic      b_odd;
   logic      nxt_par;
   logic      nxt_err_n;

   ptx_dir_ctrl u_dir (
      .dir_a2b (dir_a2b),
      .hiz_all (hiz_all),
      .en      (en)
   );

   ptx_parity_tree #(.DATA_W(DATA_W), .BALANCED(BALANCED_TREE)) u_gen_tree (
      .data (a_in),
      .odd  (a_odd)
   );

   ptx_parity_tree #(.DATA_W(DATA_W), .BALANCED(BALANCED_TREE)) u_chk_tree (
      .data (b_in),
      .odd  (b_odd)
   );

   assign nxt_par = a_odd ^ odd_sel;

   ptx_rx_check u_chk (
      .rx_live (en.a_en),
      .odd_sel (odd_sel),
      .b_odd   (b_odd),
      .par_in  (par_in),
      .err_n   (nxt_err_n)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_out   <= '0;
            b_out   <= '0;
            par_out <= 1'b0;
            err_n   <= 1'b1;
            a_oe    <= 1'b0;
            b_oe    <= 1'b0;
            par_oe  <= 1'b0;
            err_oe  <= 1'b0;
         end else begin
            a_out   <= b_in;
            b_out   <= a_in;
            par_out <= nxt_par;
            err_n   <= nxt_err_n;
            a_oe    <= en.a_en;
            b_oe    <= en.b_en;
            par_oe  <= en.par_en;
            err_oe  <= en.err_en;
         end
      end
   end else begin : g_comb
      assign a_out   = b_in;
      assign b_out   = a_in;
      assign par_out = nxt_par;
      assign err_n   = nxt_err_n;
      assign a_oe    = en.a_en;
      assign b_oe    = en.b_en;
      assign par_oe  = en.par_en;
      assign err_oe  = en.err_en;
   end
endmodule

// File: rtl/ptx_xcvr_checker.sv
module ptx_xcvr_checker #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dir_a2b,
   input logic              hiz_all,
   input logic              odd_sel,
   input logic [DATA_W-1:0] a_in,
   input logic [DATA_W-1:0] a_out,
   input logic              a_oe,
   input logic [DATA_W-1:0] b_in,
   input logic [DATA_W-1:0] b_out,
   input logic              b_oe,
   input logic              par_in,
   input logic              par_out,
   input logic              par_oe,
   input logic              err_n,
   input logic              err_oe
);
   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   assert_one_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_oe && b_oe));

   if (REG_OUT) begin : g_reg_props
      assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
         live && $past(hiz_all) |-> !a_oe && !b_oe && !par_oe && !err_oe && err_n);
      assert_a2b_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
         live && $past(!hiz_all && dir_a2b) |-> b_oe && !a_oe && (b_out == $past(a_in)));
      assert_b2a_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
         live && $past(!hiz_all && !dir_a2b) |-> a_oe && !b_oe && (a_out == $past(b_in)));
      assert_even_gen_R4: assert property (@(posedge clk) disable iff (!rst_n)
         live && $past(!hiz_all && dir_a2b && !odd_sel) |-> par_oe && (par_out == ^$past(a_in)));
      assert_odd_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
         live && $past(!hiz_all && dir_a2b && odd_sel) |-> par_oe && (par_out != ^$past(a_in)));
      assert_rx_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
         live && $past(!hiz_all && !dir_a2b) |->
            !par_oe && err_oe && (err_n == ((^{$past(b_in), $past(par_in)}) == $past(odd_sel))));
      assert_tx_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         live && $past(!hiz_all && dir_a2b) |-> err_oe && err_n);
   end else begin : g_comb_props
      assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
         hiz_all |-> !a_oe && !b_oe && !par_oe && !err_oe && err_n);
      assert_a2b_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
         !hiz_all && dir_a2b |-> b_oe && !a_oe && (b_out == a_in));
      assert_b2a_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !hiz_all && !dir_a2b |-> a_oe && !b_oe && (a_out == b_in));
      assert_even_gen_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !hiz_all && dir_a2b && !odd_sel |-> par_oe && (par_out == ^a_in));
      assert_odd_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !hiz_all && dir_a2b && odd_sel |-> par_oe && (par_out != ^a_in));
      assert_rx_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !hiz_all && !dir_a2b |-> !par_oe && err_oe && (err_n == ((^{b_in, par_in}) == odd_sel)));
      assert_tx_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !hiz_all && dir_a2b |-> err_oe && err_n);
   end
endmodule

bind ptx_parity_xcvr ptx_xcvr_checker #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_xcvr_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dir_a2b (dir_a2b),
   .hiz_all (hiz_all),
   .odd_sel (odd_sel),
   .a_in    (a_in),
   .a_out   (a_out),
   .a_oe    (a_oe),
   .b_in    (b_in),
   .b_out   (b_out),
   .b_oe    (b_oe),
   .par_in  (par_in),
   .par_out (par_out),
   .par_oe  (par_oe),
   .err_n   (err_n),
   .err_oe  (err_oe)
);

// File: tb/tb_ptx_parity_xcvr.sv
module tb_ptx_parity_xcvr;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dir_a2b = 1'b0, hiz_all = 1'b0, odd_sel = 1'b0, par_in = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe, par_out, par_oe, err_n, err_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit mon_on   = 1'b0;
   bit finished = 1'b0;

   typedef struct {
      logic         hiz;
      logic         dir;
      logic [W-1:0] a_val;
      logic [W-1:0] b_val;
      logic         par_val;
      logic         err_val;
   } exp_t;

   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ptx_parity_xcvr #(.DATA_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .dir_a2b(dir_a2b), .hiz_all(hiz_all), .odd_sel(odd_sel),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
      .err_n(err_n), .err_oe(err_oe)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   function automatic int ones(input logic [W-1:0] v);
      int c = 0;
      for (int i = 0; i < W; i++) c += int'(v[i]);
      return c;
   endfunction

   // driver: set inputs at the falling edge and queue the prediction
   task automatic drive(input logic d, input logic h, input logic o,
                        input logic p, input logic [W-1:0] a, input logic [W-1:0] b);
      exp_t e;
      @(negedge clk);
      dir_a2b = d; hiz_all = h; odd_sel = o; par_in = p; a_in = a; b_in = b;
      e.hiz     = h;
      e.dir     = d;
      e.a_val   = b;
      e.b_val   = a;
      // R4/R5: bit makes the total count even (even select) or odd (odd select)
      e.par_val = ((ones(a) % 2) == 1) ^ o;
      // R6/R7: no error when (ones in B + parity) parity matches the select
      if (!h && !d) e.err_val = (((ones(b) + int'(p)) % 2) == int'(o));
      else          e.err_val = 1'b1;
      sb_q.push_back(e);
   endtask

   // monitor: one edge of latency (R8), sampled a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (mon_on && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk("R9 single driver", W'(a_oe & b_oe), '0);
         chk("R3/R6/R7 err_n level", W'(err_n), W'(e.err_val));
         if (e.hiz) begin
            chk("R3 all released", W'({a_oe, b_oe, par_oe, err_oe}), '0);
         end else if (e.dir) begin
            chk("R1 enables", W'({a_oe, b_oe}), W'(2'b01));
            chk("R1 b_out", b_out, e.b_val);
            chk("R4/R5 par_oe", W'(par_oe), W'(1));
            chk("R4/R5 par_out", W'(par_out), W'(e.par_val));
            chk("R7 err_oe", W'(err_oe), W'(1));
         end else begin
            chk("R2 enables", W'({a_oe, b_oe}), W'(2'b10));
            chk("R2 a_out", a_out, e.a_val);
            chk("R6 par_oe low", W'(par_oe), '0);
            chk("R6 err_oe", W'(err_oe), W'(1));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R8 reset state, with inputs asking for transmit
      dir_a2b = 1'b1; a_in = 8'hA5; b_in = 8'h3C; par_in = 1'b1;
      repeat (2) @(posedge clk);
      #(CLK_PERIOD/4);
      chk("R8 reset enables", W'({a_oe, b_oe, par_oe, err_oe}), '0);
      chk("R8 reset err_n", W'(err_n), W'(1));
      chk("R8 reset data", a_out | b_out | W'(par_out), '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8 latency: a new input shows only after the next rising edge
      @(negedge clk);
      dir_a2b = 1'b1; hiz_all = 1'b0; odd_sel = 1'b0; a_in = 8'h3C;
      @(posedge clk); #(CLK_PERIOD/4);
      chk("R8 first value", b_out, 8'h3C);
      @(negedge clk);
      a_in = 8'hC3;
      #1;
      chk("R8 value held before edge", b_out, 8'h3C);
      @(posedge clk); #(CLK_PERIOD/4);
      chk("R8 value after edge", b_out, 8'hC3);

      // exhaustive sweep, direction toggling every cycle
      mon_on = 1'b1;
      for (int a = 0; a < 256; a++) begin
         for (int c = 0; c < 16; c++) begin
            logic [3:0] cb;
            cb = 4'(c);
            drive(cb[0], cb[3], cb[1], cb[2], 8'(a), 8'(a * 37 + c * 11));
         end
      end
      // release arriving together with a wrong parity on B (R3 over R6)
      drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h01);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h01);
      @(negedge clk);
      hiz_all = 1'b1;
      wait (sb_q.size() == 0);
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule